// File: doc/BRIEF.md
# Dual FIFO with Watermark Transfer Requests

This block holds two 16-entry data FIFOs side by side. The transmit FIFO is filled by a CPU or DMA agent and drained by a serial engine. The receive FIFO is filled by the serial engine and drained by the CPU or DMA agent. Each FIFO drives a level-sensitive transfer request toward the CPU/DMA side. The transmit request tracks free space and the receive request tracks fill level. Each compares its count against a threshold selected by a 3-bit watermark code.

Each side reports its live count as a 5-bit value: free entries for transmit, valid entries for receive. A write into a full FIFO or a read from an empty FIFO sets a sticky error flag. A dedicated clear input resets these flags. Requests, counts, read data and flags are all registered. They show the state after the clock edge on which a push or pop is taken.

Top module: `wm_fifo_req`

## Requirements
- R1: Each FIFO holds exactly 16 entries. `tx_free` shows the number of empty transmit entries and `rx_used` shows the number of valid receive entries, each from 0 to 16. Each count updates on the clock edge that takes the push or pop.
- R2: The watermark code selects a threshold: 3'b000 selects 1, 3'b100 selects 4, 3'b101 selects 8, 3'b110 selects 12 and 3'b111 selects 16. The unused codes 3'b001, 3'b010 and 3'b011 select 1.
- R3: After every clock edge, `tx_req` is 1 exactly when the free count after that edge is at least the threshold of the `tx_wm` value sampled at that edge. With code 3'b000 the threshold is 1.
- R4: After every clock edge, `rx_req` is 1 exactly when the valid count after that edge is at least the threshold of the `rx_wm` value sampled at that edge. With code 3'b111, `rx_req` is 1 only when all 16 entries hold data.
- R5: A request falls on the same edge at which its count drops below the threshold, even when the FIFO is neither empty nor full.
- R6: A push into a full FIFO is dropped, and the count and the stored data are left unchanged. It sets that side's overflow flag, which then stays 1.
- R7: A pop from an empty FIFO leaves the count and the read data unchanged. It sets that side's underflow flag, which then stays 1.
- R8: `err_clr` clears all four error flags on the next edge. An error that happens on that same edge keeps its flag set.
- R9: A push and a pop taken together on a FIFO that is neither empty nor full leave the count unchanged.
- R10: Data leaves each FIFO in the order it was written. The popped word appears on the read-data output after the edge that takes the pop, and stays there until the next successful pop.
- R11: A synchronous reset empties both FIFOs. After reset `tx_free`=16, `rx_used`=0, `tx_req`=1, `rx_req`=0, all flags are 0 and both read-data outputs are 0.
- R12: A change of watermark code alters only the request. It flushes no data and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_clr | input | 1 | Clears all sticky error flags |
| tx_push | input | 1 | Write a word into the transmit FIFO |
| tx_wdata | input | 8 | Transmit write data |
| tx_pop | input | 1 | Read a word from the transmit FIFO |
| tx_rdata | output | 8 | Last word popped from the transmit FIFO |
| tx_wm | input | 3 | Transmit watermark code |
| tx_req | output | 1 | Transmit transfer request |
| tx_free | output | 5 | Free transmit entries |
| tx_ovf | output | 1 | Transmit overflow flag |
| tx_unf | output | 1 | Transmit underflow flag |
| rx_push | input | 1 | Write a word into the receive FIFO |
| rx_wdata | input | 8 | Receive write data |
| rx_pop | input | 1 | Read a word from the receive FIFO |
| rx_rdata | output | 8 | Last word popped from the receive FIFO |
| rx_wm | input | 3 | Receive watermark code |
| rx_req | output | 1 | Receive transfer request |
| rx_used | output | 5 | Valid receive entries |
| rx_ovf | output | 1 | Receive overflow flag |
| rx_unf | output | 1 | Receive underflow flag |

## Verification
The first pattern is a one-word-at-a-time fill and drain under each of the eight codes. It separates every threshold from its neighbours, because a request that flips one entry early or late shows a mismatch at exactly that count. Deliberate pushes past full and pops past empty check that the errors are dropped and that the flags are sticky and cleared. These include a clear on the same edge as a fresh error. Held-level cycles with simultaneous push and pop, and code changes with the data held, show that only the request moves. Random phases that lean toward filling, draining or balanced traffic, with the codes changing, then compare order, counts and flags against a queue model.

// File: rtl/wm_pkg.sv
package wm_pkg;

    // Watermark code points; the remaining codes are reserved.
    typedef enum logic [2:0] {
        WM_ONE     = 3'b000,
        WM_QUARTER = 3'b100,
        WM_HALF    = 3'b101,
        WM_3QUART  = 3'b110,
        WM_ALL     = 3'b111
    } wm_code_e;

    localparam int WM_CODE_W = 3;

endpackage

// File: rtl/wm_decode.sv
module wm_decode
    import wm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [WM_CODE_W-1:0] code,
    output logic [CNT_W-1:0]     thr
);

    localparam logic [CNT_W-1:0] T_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] T_QTR  = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] T_3Q   = CNT_W'((3 * DEPTH) / 4);
    localparam logic [CNT_W-1:0] T_ALL  = CNT_W'(DEPTH);

    always_comb begin
        case (code)
            WM_QUARTER: thr = T_QTR;
            WM_HALF:    thr = T_HALF;
            WM_3QUART:  thr = T_3Q;
            WM_ALL:     thr = T_ALL;
            default:    thr = T_ONE;   // 000 and reserved codes (R2)
        endcase
    end

endmodule

// File: rtl/wm_fifo_chan.sv
module wm_fifo_chan #(
    parameter int WIDTH       = 8,
    parameter int DEPTH       = 16,
    parameter int CNT_W       = $clog2(DEPTH + 1),
    parameter bit REPORT_FREE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    input  logic [CNT_W-1:0] thr,
    output logic             req,
    output logic [CNT_W-1:0] level,
    output logic             ovf,
    output logic             unf
);

    localparam int              PTR_W   = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] used;
        logic [WIDTH-1:0] rdata;
        logic             req;
        logic             ovf;
        logic             unf;
    } chan_st_t;

    chan_st_t         st_q, st_d;
    logic [WIDTH-1:0] mem_q [DEPTH];

    logic             full, empty, do_push, do_pop;
    logic [CNT_W-1:0] level_d;

    assign full    = (st_q.used == DEPTH_C);
    assign empty   = (st_q.used == '0);
    assign do_push = push && !full && !rst;
    assign do_pop  = pop && !empty && !rst;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = st_q.wr + 1'b1;
        if (do_pop) begin
            st_d.rd    = st_q.rd + 1'b1;
            st_d.rdata = mem_q[st_q.rd];
        end
        case ({do_push, do_pop})
            2'b10:   st_d.used = st_q.used + 1'b1;
            2'b01:   st_d.used = st_q.used - 1'b1;
            default: st_d.used = st_q.used;
        endcase
        st_d.ovf = (st_q.ovf && !err_clr) || (push && full);
        st_d.unf = (st_q.unf && !err_clr) || (pop && empty);
        if (rst) begin
            st_d.wr    = '0;
            st_d.rd    = '0;
            st_d.used  = '0;
            st_d.rdata = '0;
            st_d.ovf   = 1'b0;
            st_d.unf   = 1'b0;
        end
        level_d  = REPORT_FREE ? (DEPTH_C - st_d.used) : st_d.used;
        st_d.req = (level_d >= thr);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign rdata = st_q.rdata;
    assign req   = st_q.req;
    assign level = REPORT_FREE ? (DEPTH_C - st_q.used) : st_q.used;
    assign ovf   = st_q.ovf;
    assign unf   = st_q.unf;

    // R1: occupancy never leaves 0..DEPTH
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.used <= DEPTH_C);

    // R3 / R4 / R5: request matches level against the threshold seen at the last edge
    a_r5_req_level: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (req == (level >= $past(thr))));

    // R6: overflowing push changes nothing and raises the flag
    a_r6_ovf_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (ovf && $stable(level)));

    // R6 / R7: flags are sticky until cleared
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !err_clr) |=> ovf);
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (unf && !err_clr) |=> unf);

    // R7: popping empty keeps the read data
    a_r7_unf_hold: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (unf && $stable(rdata)));

    // R8: clear without new error drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !(push && full)) |=> !ovf);

    // R9: balanced push/pop keeps the level
    a_r9_balanced: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> $stable(level));

endmodule

// File: rtl/wm_fifo_req.sv
module wm_fifo_req
    import wm_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_clr,
    input  logic                 tx_push,
    input  logic [WIDTH-1:0]     tx_wdata,
    input  logic                 tx_pop,
    output logic [WIDTH-1:0]     tx_rdata,
    input  logic [WM_CODE_W-1:0] tx_wm,
    output logic                 tx_req,
    output logic [CNT_W-1:0]     tx_free,
    output logic                 tx_ovf,
    output logic                 tx_unf,
    input  logic                 rx_push,
    input  logic [WIDTH-1:0]     rx_wdata,
    input  logic                 rx_pop,
    output logic [WIDTH-1:0]     rx_rdata,
    input  logic [WM_CODE_W-1:0] rx_wm,
    output logic                 rx_req,
    output logic [CNT_W-1:0]     rx_used,
    output logic                 rx_ovf,
    output logic                 rx_unf
);

    logic [CNT_W-1:0] tx_thr, rx_thr;

    wm_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_dec (.code(tx_wm), .thr(tx_thr));
    wm_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_dec (.code(rx_wm), .thr(rx_thr));

    wm_fifo_chan #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W), .REPORT_FREE(1'b1)) u_tx (
        .clk(clk), .rst(rst), .err_clr(err_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .thr(tx_thr), .req(tx_req), .level(tx_free), .ovf(tx_ovf), .unf(tx_unf)
    );

    wm_fifo_chan #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W), .REPORT_FREE(1'b0)) u_rx (
        .clk(clk), .rst(rst), .err_clr(err_clr),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .thr(rx_thr), .req(rx_req), .level(rx_used), .ovf(rx_ovf), .unf(rx_unf)
    );

endmodule

// File: tb/wm_fifo_req_test.sv
module wm_fifo_req_test;

    logic       clk = 1'b0;
    logic       rst, err_clr;
    logic       tx_push, tx_pop, rx_push, rx_pop;
    logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [2:0] tx_wm, rx_wm;
    logic       tx_req, rx_req, tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [4:0] tx_free, rx_used;

    int checks = 0, fails = 0;
    bit done = 0;
    string ctx = "init";

    logic [7:0] qt[$], qr[$];
    logic [7:0] e_trd = 0, e_rrd = 0;
    logic e_tovf = 0, e_tunf = 0, e_rovf = 0, e_runf = 0;

    always #2ns clk = ~clk;   // 250 MHz

    wm_fifo_req uut (
        .clk(clk), .rst(rst), .err_clr(err_clr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_wm(tx_wm), .tx_req(tx_req), .tx_free(tx_free), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_wm(rx_wm), .rx_req(rx_req), .rx_used(rx_used), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    function automatic int thr_of(input logic [2:0] c);   // R2 table
        case (c)
            3'b100:  return 4;
            3'b101:  return 8;
            3'b110:  return 12;
            3'b111:  return 16;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, ctx, act, exp);
        end
    endtask

    task automatic upd(ref logic [7:0] q[$], input logic push, input logic pop,
                       input logic [7:0] wd, ref logic [7:0] rd, ref logic ov, ref logic un);
        bit full = (q.size() == 16);
        bit emp  = (q.size() == 0);
        if (pop && !emp) rd = q.pop_front();
        if (push && !full) q.push_back(wd);
        ov = (ov && !err_clr) || (push && full);
        un = (un && !err_clr) || (pop && emp);
    endtask

    task automatic check_all();
        chk("R1 tx_free", tx_free, 16 - qt.size());
        chk("R1 rx_used", rx_used, qr.size());
        chk("R3 tx_req", tx_req, int'((16 - qt.size()) >= thr_of(tx_wm)));
        chk("R4 rx_req", rx_req, int'(qr.size() >= thr_of(rx_wm)));
        chk("R10 tx_rdata", tx_rdata, e_trd);
        chk("R10 rx_rdata", rx_rdata, e_rrd);
        chk("R6 tx_ovf", tx_ovf, e_tovf);
        chk("R6 rx_ovf", rx_ovf, e_rovf);
        chk("R7 tx_unf", tx_unf, e_tunf);
        chk("R7 rx_unf", rx_unf, e_runf);
    endtask

    // inputs are already set at a falling edge; take one rising edge and check
    task automatic cyc();
        @(posedge clk);
        #1ns;
        upd(qt, tx_push, tx_pop, tx_wdata, e_trd, e_tovf, e_tunf);
        upd(qr, rx_push, rx_pop, rx_wdata, e_rrd, e_rovf, e_runf);
        check_all();
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; err_clr = 0;
        tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
    endtask

    task automatic idle();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; err_clr = 0;
    endtask

    task automatic clear_err();
        err_clr = 1; cyc();
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle(); tx_wdata = 0; rx_wdata = 0; tx_wm = 3'b000; rx_wm = 3'b000;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11: reset state, before any further edge
        ctx = "R11";
        chk("R11 tx_free", tx_free, 16);
        chk("R11 rx_used", rx_used, 0);
        chk("R11 tx_req", tx_req, 1);
        chk("R11 rx_req", rx_req, 0);
        chk("R11 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        chk("R11 rdata", {tx_rdata, rx_rdata}, 0);

        // R2: every code, fill and drain one word at a time on both sides
        for (int c = 0; c < 8; c++) begin
            ctx = $sformatf("R2 code %0d", c);
            tx_wm = 3'(c); rx_wm = 3'(c);
            cyc();
            for (int i = 0; i < 16; i++) begin tx_push = 1; rx_push = 1; cyc(); end
            ctx = $sformatf("R5 drain code %0d", c);
            for (int i = 0; i < 16; i++) begin tx_pop = 1; rx_pop = 1; cyc(); end
        end

        // R6: overflow on full, flag sticky; R8 clear
        ctx = "R6";
        rx_wm = 3'b111;
        for (int i = 0; i < 16; i++) begin rx_push = 1; tx_push = 1; cyc(); end
        rx_push = 1; tx_push = 1; cyc();
        rx_push = 1; cyc();
        repeat (3) cyc();
        ctx = "R8 clear";
        clear_err();
        chk("R8 rx_ovf cleared", rx_ovf, 0);
        ctx = "R8 clear+error";
        err_clr = 1; rx_push = 1; cyc();
        chk("R8 rx_ovf kept", rx_ovf, 1);
        clear_err();

        // R9: balanced push/pop at mid level
        ctx = "R9";
        for (int i = 0; i < 8; i++) begin rx_pop = 1; tx_pop = 1; cyc(); end
        for (int i = 0; i < 6; i++) begin
            rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1; cyc();
            chk("R9 rx_used", rx_used, 8);
        end

        // R12: code changes with data held
        ctx = "R12";
        for (int c = 0; c < 8; c++) begin
            tx_wm = 3'(c); rx_wm = 3'(7 - c); cyc();
            chk("R12 rx_used", rx_used, 8);
            chk("R12 tx_free", tx_free, 8);
        end

        // R7: underflow, read data held
        ctx = "R7";
        for (int i = 0; i < 8; i++) begin rx_pop = 1; tx_pop = 1; cyc(); end
        tx_pop = 1; rx_pop = 1; cyc();
        tx_pop = 1; rx_push = 1; rx_pop = 1; cyc();
        repeat (2) cyc();
        clear_err();

        // random phases: fill-leaning, drain-leaning, balanced
        for (int ph = 0; ph < 12; ph++) begin
            int pp = (ph % 3 == 0) ? 75 : (ph % 3 == 1) ? 25 : 50;
            ctx = $sformatf("random phase %0d", ph);
            for (int n = 0; n < 400; n++) begin
                if ($urandom_range(49) == 0) tx_wm = 3'($urandom);
                if ($urandom_range(49) == 0) rx_wm = 3'($urandom);
                tx_push = ($urandom_range(99) < pp);
                rx_push = ($urandom_range(99) < pp);
                tx_pop  = ($urandom_range(99) < 100 - pp);
                rx_pop  = ($urandom_range(99) < 100 - pp);
                err_clr = ($urandom_range(29) == 0);
                cyc();
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule